// File: doc/BRIEF.md
# Video Sync Mode Detector

This block watches the horizontal and vertical sync inputs of a display controller. It times them against a reference tick, which is derived from the system clock by a fixed divider. Each sync period is measured in reference ticks. The block also finds which level of each sync is the active pulse and decides whether each sync is present. A result is only passed to the register-style outputs once it has stayed stable over several frames. From the two presence bits the block derives a display power state.

Software sees the committed periods, polarities, presence bits and power state on plain output ports. A single interrupt flag tells software that the committed mode has actually changed. A repeated commit of the same mode leaves the flag alone.

Detection can be halted with an enable register to save power. While it is halted, the last committed mode stays on the outputs. The interrupt flag is cleared by an acknowledge strobe or by a software clear strobe. A mode input picks which of the two applies.

Top module: `sync_mode_detect`

## Requirements
- R1: The enable register `en_o` reads 1 after reset. Writing 0 through `en_wr`/`en_wdata` halts measurement. While halted, the committed outputs do not change and `irq` is not set. Writing 1 restarts measurement from scratch.
- R2: A measurement is committed only after it has been stable for `SETTLE` (5) consecutive frame events. Stable means both periods are within `TOL` (2) ticks of the previous frame event and both raw polarities are unchanged. After reset, no commit and no `irq` can occur within the first four vertical frames.
- R3: Periods are reported in reference ticks, counted from one rising edge of the sync to the next. A sync that stops toggling reads as the all-ones value of its counter width.
- R4: `h_present` is 1 only when the committed horizontal period is non-zero and at most `H_MAX_PER`. The default of 66 ticks at 1 MHz corresponds to 15 kHz. `v_present` uses the same rule with `V_MAX_PER`, whose default of 25000 ticks corresponds to 40 Hz.
- R5: A polarity bit of 1 means the sync is active-high, that is, its high time is shorter than its low time. A polarity bit of 0 means active-low. An absent sync reports polarity 0.
- R6: When horizontal sync is present and vertical sync is absent, `h_pol` is forced to 0.
- R7: `pwr_state` is 2'b00 when both syncs are present (normal) and 2'b01 when only horizontal is present (standby). It is 2'b10 when only vertical is present (suspend) and 2'b11 when neither is present (off). Reset value is 2'b11.
- R8: `irq` is set by a commit when one of these holds: it is the first commit since reset, a presence bit changes, a polarity bit changes, or a present sync's period moves by more than `TOL` ticks. A commit of an unchanged mode leaves `irq` at 0.
- R9: With `irq_edge_mode`=1, a pulse on `irq_ack` clears `irq`, and `irq_swclr` has no effect.
- R10: With `irq_edge_mode`=0, a pulse on `irq_swclr` clears `irq`, and `irq_ack` has no effect.
- R11: When no vertical edge arrives for `TIMEOUT` ticks, a frame event is generated anyway. A mode with vertical sync absent therefore still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 1 | Value written to the enable register |
| en_o | output | 1 | Enable register value |
| irq_edge_mode | input | 1 | 1: acknowledge clears irq; 0: software clear clears irq |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_swclr | input | 1 | Software clear strobe |
| h_period | output | H_CNT_W | Committed horizontal period in ticks |
| v_period | output | V_CNT_W | Committed vertical period in ticks |
| h_pol | output | 1 | Committed horizontal polarity, 1 = active-high |
| v_pol | output | 1 | Committed vertical polarity, 1 = active-high |
| h_present | output | 1 | Horizontal sync present |
| v_present | output | 1 | Vertical sync present |
| pwr_state | output | 2 | Power state code |
| irq | output | 1 | Mode change interrupt flag |

## Verification
A sync change reaches the outputs only after a chain of steps:
- the two-flop synchronizer,
- a full period capture,
- a run of `SETTLE` stable frame events,
- two more register stages.

The outputs and `irq` therefore settle between six and about nine frame events after the stimulus. A frame event is either a vertical edge or a `TIMEOUT` expiry. The bench waits fourteen frame lengths before it samples any committed result. It checks that `irq` is still low four frames after reset. Strobes take effect on the next clock edge, so the bench checks `irq` one cycle after each strobe. Measured periods are compared against the nominal tick count with a one-tick allowance for the phase of the divider.

// File: rtl/sync_mode_pkg.sv
// Shared types for the sync mode detector.
// Assumes nothing beyond a standard elaboration order (package first).
package sync_mode_pkg;

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_STANDBY = 2'b01,
        PWR_SUSPEND = 2'b10,
        PWR_OFF     = 2'b11
    } pwr_state_t;

    // Map the two presence bits onto a power state code.
    function automatic pwr_state_t pwr_from(input logic h_on, input logic v_on);
        unique case ({h_on, v_on})
            2'b11:   return PWR_NORMAL;
            2'b10:   return PWR_STANDBY;
            2'b01:   return PWR_SUSPEND;
            default: return PWR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/smd_tick_gen.sv
// Reference tick generator: one-cycle pulse every DIV clocks while run is high.
// Assumes DIV >= 1; the divider restarts whenever run is low.
module smd_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Divide the system clock down to the reference rate.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/smd_sync_meter.sv
// Period and polarity meter for one sync input.
// Synchronises the input, counts reference ticks between rising edges and
// the ticks spent high in that period. Counters saturate at all-ones; a
// saturated counter is reported as the period so a stuck sync reads as max.
// edge_stb pulses one cycle after a rising edge, when the capture is valid.
module smd_sync_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             sync_in,
    output logic [CNT_W-1:0] period,
    output logic             active_high,
    output logic             edge_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]       shift_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] hper_q;
    logic [CNT_W:0]   hi_twice;

    assign rise = shift_q[1] & ~shift_q[2];

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) shift_q <= '0;
        else                shift_q <= {shift_q[1:0], sync_in};
    end

    // Running tick counters for the whole period and its high part.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || rise) begin
            cnt_q <= '0;
            hi_q  <= '0;
        end else if (tick) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (shift_q[1] && hi_q != CNT_MAX) hi_q <= hi_q + 1'b1;
        end
    end

    // Capture the finished period on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            per_q    <= '0;
            hper_q   <= '0;
            edge_stb <= 1'b0;
        end else begin
            edge_stb <= rise;
            if (rise) begin
                per_q  <= cnt_q;
                hper_q <= hi_q;
            end
        end
    end

    assign period      = (cnt_q == CNT_MAX) ? CNT_MAX : per_q;
    assign hi_twice    = {hper_q, 1'b0};
    assign active_high = hi_twice < {1'b0, per_q};
endmodule

// File: rtl/smd_settle.sv
// Frame sequencer and stability filter.
// A frame event is a vertical capture or a TIMEOUT-tick gap without one.
// On each frame event the current measurements are compared with the ones
// from the previous event; SETTLE stable comparisons in a row produce a
// commit pulse one cycle later, with the sample held on the s_* outputs.
module smd_settle #(
    parameter int HW      = 12,
    parameter int VW      = 17,
    parameter int TIMEOUT = 100000,
    parameter int SETTLE  = 5,
    parameter int TOL     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          v_edge,
    input  logic [HW-1:0] h_per,
    input  logic [VW-1:0] v_per,
    input  logic          h_ah,
    input  logic          v_ah,
    output logic          commit,
    output logic [HW-1:0] s_hper,
    output logic [VW-1:0] s_vper,
    output logic          s_hah,
    output logic          s_vah
);
    localparam int TW   = $clog2(TIMEOUT + 1);
    localparam int SC_W = $clog2(SETTLE + 1);
    localparam logic [TW-1:0]   TMR_LAST = TW'(TIMEOUT - 1);
    localparam logic [SC_W-1:0] STAB_MAX = SC_W'(SETTLE);
    localparam logic [SC_W-1:0] STAB_ARM = SC_W'(SETTLE - 1);

    logic [TW-1:0]   tmr_q;
    logic [SC_W-1:0] stab_q;
    logic            prev_ok;
    logic            tmo;
    logic            frame_ev;
    logic            close;

    function automatic logic h_near(input logic [HW-1:0] a, input logic [HW-1:0] b);
        logic [HW-1:0] d;
        d = (a > b) ? a - b : b - a;
        return d <= HW'(TOL);
    endfunction

    function automatic logic v_near(input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] d;
        d = (a > b) ? a - b : b - a;
        return d <= VW'(TOL);
    endfunction

    assign tmo      = tick && (tmr_q == TMR_LAST);
    assign frame_ev = v_edge || tmo;
    assign close    = prev_ok && h_near(h_per, s_hper) && v_near(v_per, s_vper)
                      && (h_ah == s_hah) && (v_ah == s_vah);

    // Timeout timer that stands in for a missing vertical edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || frame_ev) tmr_q <= '0;
        else if (tick)                  tmr_q <= tmr_q + 1'b1;
    end

    // Keep the last sample and count consecutive stable frame events.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            stab_q  <= '0;
            prev_ok <= 1'b0;
            s_hper  <= '0;
            s_vper  <= '0;
            s_hah   <= 1'b0;
            s_vah   <= 1'b0;
        end else if (frame_ev) begin
            if (!close)                stab_q <= '0;
            else if (stab_q != STAB_MAX) stab_q <= stab_q + 1'b1;
            prev_ok <= 1'b1;
            s_hper  <= h_per;
            s_vper  <= v_per;
            s_hah   <= h_ah;
            s_vah   <= v_ah;
        end
    end

    // Issue a commit once the stable run has reached SETTLE.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) commit <= 1'b0;
        else                commit <= frame_ev && close && (stab_q >= STAB_ARM);
    end
endmodule

// File: rtl/sync_mode_detect.sv
// Top of the sync mode detector.
// Measures both syncs, filters them over frames, and on each commit turns
// the sample into presence, polarity and power state; the interrupt flag is
// raised only when that committed mode differs from the one before it.
// Assumes H_MAX_PER < 2**H_CNT_W - 1 and V_MAX_PER < 2**V_CNT_W - 1.
module sync_mode_detect
    import sync_mode_pkg::*;
#(
    parameter int REF_DIV   = 125,
    parameter int H_CNT_W   = 12,
    parameter int V_CNT_W   = 17,
    parameter int H_MAX_PER = 66,
    parameter int V_MAX_PER = 25000,
    parameter int TIMEOUT   = 100000,
    parameter int SETTLE    = 5,
    parameter int TOL       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync_in,
    input  logic               vsync_in,
    input  logic               en_wr,
    input  logic               en_wdata,
    output logic               en_o,
    input  logic               irq_edge_mode,
    input  logic               irq_ack,
    input  logic               irq_swclr,
    output logic [H_CNT_W-1:0] h_period,
    output logic [V_CNT_W-1:0] v_period,
    output logic               h_pol,
    output logic               v_pol,
    output logic               h_present,
    output logic               v_present,
    output logic [1:0]         pwr_state,
    output logic               irq
);
    localparam logic [H_CNT_W-1:0] H_LIM = H_CNT_W'(H_MAX_PER);
    localparam logic [V_CNT_W-1:0] V_LIM = V_CNT_W'(V_MAX_PER);
    localparam logic               H_FIXED_POL = 1'b0;

    logic               en_q;
    logic               tick;
    logic [H_CNT_W-1:0] h_meas;
    logic [V_CNT_W-1:0] v_meas;
    logic               h_meas_ah;
    logic               v_meas_ah;
    logic               h_edge_unused;
    logic               v_edge;
    logic               commit;
    logic [H_CNT_W-1:0] s_hper;
    logic [V_CNT_W-1:0] s_vper;
    logic               s_hah;
    logic               s_vah;
    logic               new_hp;
    logic               new_vp;
    logic               new_hpol;
    logic               new_vpol;
    logic               mode_diff;
    logic               known_q;
    logic               irq_q;
    pwr_state_t         pwr_q;

    function automatic logic h_far(input logic [H_CNT_W-1:0] a, input logic [H_CNT_W-1:0] b);
        logic [H_CNT_W-1:0] d;
        d = (a > b) ? a - b : b - a;
        return d > H_CNT_W'(TOL);
    endfunction

    function automatic logic v_far(input logic [V_CNT_W-1:0] a, input logic [V_CNT_W-1:0] b);
        logic [V_CNT_W-1:0] d;
        d = (a > b) ? a - b : b - a;
        return d > V_CNT_W'(TOL);
    endfunction

    // Enable register, set after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b1;
        else if (en_wr) en_q <= en_wdata;
    end

    smd_tick_gen #(.DIV(REF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en_q),
        .tick (tick)
    );

    smd_sync_meter #(.CNT_W(H_CNT_W)) u_hmeter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .tick       (tick),
        .sync_in    (hsync_in),
        .period     (h_meas),
        .active_high(h_meas_ah),
        .edge_stb   (h_edge_unused)
    );

    smd_sync_meter #(.CNT_W(V_CNT_W)) u_vmeter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .tick       (tick),
        .sync_in    (vsync_in),
        .period     (v_meas),
        .active_high(v_meas_ah),
        .edge_stb   (v_edge)
    );

    smd_settle #(
        .HW(H_CNT_W), .VW(V_CNT_W), .TIMEOUT(TIMEOUT), .SETTLE(SETTLE), .TOL(TOL)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .tick  (tick),
        .v_edge(v_edge),
        .h_per (h_meas),
        .v_per (v_meas),
        .h_ah  (h_meas_ah),
        .v_ah  (v_meas_ah),
        .commit(commit),
        .s_hper(s_hper),
        .s_vper(s_vper),
        .s_hah (s_hah),
        .s_vah (s_vah)
    );

    // Decide presence, masked polarities and whether the mode moved.
    always_comb begin
        new_hp    = (s_hper != '0) && (s_hper <= H_LIM);
        new_vp    = (s_vper != '0) && (s_vper <= V_LIM);
        new_hpol  = new_hp && (new_vp ? s_hah : H_FIXED_POL);
        new_vpol  = new_vp && s_vah;
        mode_diff = !known_q
                    || (new_hp != h_present) || (new_vp != v_present)
                    || (new_hpol != h_pol) || (new_vpol != v_pol)
                    || (new_hp && h_far(s_hper, h_period))
                    || (new_vp && v_far(s_vper, v_period));
    end

    // Committed mode registers, refreshed on every commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_period  <= '0;
            v_period  <= '0;
            h_pol     <= 1'b0;
            v_pol     <= 1'b0;
            h_present <= 1'b0;
            v_present <= 1'b0;
            pwr_q     <= PWR_OFF;
            known_q   <= 1'b0;
        end else if (commit) begin
            h_period  <= s_hper;
            v_period  <= s_vper;
            h_pol     <= new_hpol;
            v_pol     <= new_vpol;
            h_present <= new_hp;
            v_present <= new_vp;
            pwr_q     <= pwr_from(new_hp, new_vp);
            known_q   <= 1'b1;
        end
    end

    // Interrupt flag: set on a real change, cleared by the selected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      irq_q <= 1'b0;
        else if (commit && mode_diff)                    irq_q <= 1'b1;
        else if (irq_edge_mode ? irq_ack : irq_swclr)    irq_q <= 1'b0;
    end

    assign en_o      = en_q;
    assign irq       = irq_q;
    assign pwr_state = pwr_q;
endmodule

// File: rtl/smd_checker.sv
// Property checker for sync_mode_detect, attached by bind below.
// Observes only the top-level ports.
module smd_checker #(
    parameter int H_CNT_W   = 12,
    parameter int V_CNT_W   = 17,
    parameter int H_MAX_PER = 66,
    parameter int V_MAX_PER = 25000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_o,
    input logic               irq_edge_mode,
    input logic               irq_ack,
    input logic               irq_swclr,
    input logic [H_CNT_W-1:0] h_period,
    input logic [V_CNT_W-1:0] v_period,
    input logic               h_pol,
    input logic               v_pol,
    input logic               h_present,
    input logic               v_present,
    input logic [1:0]         pwr_state,
    input logic               irq
);
    localparam logic [H_CNT_W-1:0] H_LIM = H_CNT_W'(H_MAX_PER);
    localparam logic [V_CNT_W-1:0] V_LIM = V_CNT_W'(V_MAX_PER);

    assert_pwr_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == {~h_present, ~v_present});

    assert_hpol_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_present && !v_present) |-> !h_pol);

    assert_absent_hpol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !h_present |-> !h_pol);

    assert_absent_vpol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !v_present |-> !v_pol);

    assert_h_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_present |-> (h_period != '0 && h_period <= H_LIM));

    assert_v_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_present |-> (v_period != '0 && v_period <= V_LIM));

    assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && $past(!en_o) && $past(!en_o, 2)) |->
            ($stable(h_period) && $stable(v_period) && $stable(pwr_state) && !$rose(irq)));

    assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && $past(irq_edge_mode) && $past(!irq_ack)) |-> irq);

    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && $past(!irq_edge_mode) && $past(!irq_swclr)) |-> irq);
endmodule

bind sync_mode_detect smd_checker #(
    .H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W), .H_MAX_PER(H_MAX_PER), .V_MAX_PER(V_MAX_PER)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_o         (en_o),
    .irq_edge_mode(irq_edge_mode),
    .irq_ack      (irq_ack),
    .irq_swclr    (irq_swclr),
    .h_period     (h_period),
    .v_period     (v_period),
    .h_pol        (h_pol),
    .v_pol        (v_pol),
    .h_present    (h_present),
    .v_present    (v_present),
    .pwr_state    (pwr_state),
    .irq          (irq)
);

// File: tb/sync_mode_detect_test.sv
// Bench for sync_mode_detect in a small configuration: tick = 2 clocks,
// H present up to 20 ticks, V present up to 200 ticks, 300-tick timeout.
module sync_mode_detect_test;
    localparam int HW = 8;
    localparam int VW = 9;
    localparam int H_LIMIT = 20;
    localparam int V_LIMIT = 200;
    localparam int TMO = 300;
    localparam int H_SAT = (1 << HW) - 1;
    localparam int V_SAT = (1 << VW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0;
    logic en_wr = 1'b0, en_wdata = 1'b0;
    logic irq_edge_mode = 1'b1, irq_ack = 1'b0, irq_swclr = 1'b0;
    logic en_o, h_pol, v_pol, h_present, v_present, irq;
    logic [HW-1:0] h_period;
    logic [VW-1:0] v_period;
    logic [1:0] pwr_state;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // sync pattern controls (periods in ticks, widths in clocks)
    int h_T = 12, h_w = 4, v_T = 150, v_w = 20;
    bit h_ah = 1'b1, h_on = 1'b1, v_ah = 1'b1, v_on = 1'b1;
    int hc = 0, vc = 0;

    // model of the last committed mode
    bit m_known = 1'b0, m_hp, m_vp, m_hpol, m_vpol;
    int m_hT, m_vT;

    always #4 clk = ~clk;

    sync_mode_detect #(
        .REF_DIV(2), .H_CNT_W(HW), .V_CNT_W(VW), .H_MAX_PER(H_LIMIT),
        .V_MAX_PER(V_LIMIT), .TIMEOUT(TMO), .SETTLE(5), .TOL(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync), .vsync_in(vsync),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_o(en_o),
        .irq_edge_mode(irq_edge_mode), .irq_ack(irq_ack), .irq_swclr(irq_swclr),
        .h_period(h_period), .v_period(v_period), .h_pol(h_pol), .v_pol(v_pol),
        .h_present(h_present), .v_present(v_present), .pwr_state(pwr_state), .irq(irq)
    );

    // Sync waveform generator, driven away from the active edge.
    always @(negedge clk) begin
        if (h_on) begin
            hc = (hc + 1 >= 2 * h_T) ? 0 : hc + 1;
            hsync = (hc < h_w) ? h_ah : !h_ah;
        end else hsync = 1'b0;
        if (v_on) begin
            vc = (vc + 1 >= 2 * v_T) ? 0 : vc + 1;
            vsync = (vc < v_w) ? v_ah : !v_ah;
        end else vsync = 1'b0;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0; cycles(1);
    endtask

    task automatic pulse_clr();
        irq_swclr = 1'b1; cycles(1); irq_swclr = 1'b0; cycles(1);
    endtask

    task automatic write_en(input bit v);
        en_wr = 1'b1; en_wdata = v; cycles(1); en_wr = 1'b0; cycles(1);
    endtask

    function automatic int frame_clk();
        if (v_on && v_T < TMO) return 2 * v_T;
        return 2 * TMO;
    endfunction

    // Wait for settling, then compare every committed output with the model.
    task automatic settle_and_check(input string tag);
        bit hp, vp, hpol, vpol, chg;
        cycles(14 * frame_clk());
        hp   = h_on && (h_T <= H_LIMIT);
        vp   = v_on && (v_T <= V_LIMIT);
        hpol = hp && vp && h_ah;
        vpol = vp && v_ah;
        chg  = !m_known || hp != m_hp || vp != m_vp || hpol != m_hpol || vpol != m_vpol
               || (hp && (h_T - m_hT > 2 || m_hT - h_T > 2))
               || (vp && (v_T - m_vT > 2 || m_vT - v_T > 2));
        if (h_on) chk_rng("R3", {tag, " h_period"}, int'(h_period), h_T - 1, h_T);
        else      chk("R3", {tag, " h_period saturated"}, int'(h_period), H_SAT);
        if (v_on) chk_rng("R3", {tag, " v_period"}, int'(v_period), v_T - 1, v_T);
        else      chk("R11", {tag, " v_period saturated"}, int'(v_period), V_SAT);
        chk("R4", {tag, " h_present"}, int'(h_present), int'(hp));
        chk("R4", {tag, " v_present"}, int'(v_present), int'(vp));
        chk((hp && !vp) ? "R6" : "R5", {tag, " h_pol"}, int'(h_pol), int'(hpol));
        chk("R5", {tag, " v_pol"}, int'(v_pol), int'(vpol));
        chk("R7", {tag, " pwr_state"}, int'(pwr_state), int'({!hp, !vp}));
        chk("R8", {tag, " irq"}, int'(irq), int'(chg));
        m_known = 1'b1; m_hp = hp; m_vp = vp; m_hpol = hpol; m_vpol = vpol;
        m_hT = h_T; m_vT = v_T;
    endtask

    task automatic clear_edge(input string tag);
        pulse_ack();
        chk("R9", {tag, " irq after ack"}, int'(irq), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog expired: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        chk("R1", "reset en_o", int'(en_o), 1);
        chk("R8", "reset irq", int'(irq), 0);
        chk("R7", "reset pwr_state", int'(pwr_state), 3);
        chk("R4", "reset h_present", int'(h_present), 0);
        // R2: four vertical frames in, nothing may have committed
        cycles(4 * 2 * v_T);
        chk("R2", "irq before settle", int'(irq), 0);
        chk("R2", "pwr before settle", int'(pwr_state), 3);

        // c1: normal, both active-high; first commit raises irq (R8)
        settle_and_check("c1");
        clear_edge("c1");
        // c2: H polarity flip; swclr is ignored in edge mode (R9)
        h_ah = 1'b0;
        settle_and_check("c2");
        pulse_clr();
        chk("R9", "c2 irq kept after swclr", int'(irq), 1);
        clear_edge("c2");
        // c3: V pulse width changes, same mode -> no irq (R8)
        v_w = 30;
        settle_and_check("c3");
        // c4: H at the presence limit, period moved by 8 ticks (R4, R8)
        h_T = 20; h_ah = 1'b1;
        settle_and_check("c4");
        clear_edge("c4");
        // c5: V stuck -> standby via timeout frames, H polarity forced (R6, R11)
        v_on = 1'b0;
        settle_and_check("c5");
        clear_edge("c5");
        // c6: H stuck, V active-low -> suspend
        h_on = 1'b0; v_on = 1'b1; v_ah = 1'b0; v_w = 20;
        settle_and_check("c6");
        clear_edge("c6");
        // c7: both stuck -> off (R11)
        v_on = 1'b0;
        settle_and_check("c7");
        clear_edge("c7");
        // c8: H just over the limit (22 ticks) -> absent; V at 180 ticks
        h_on = 1'b1; h_T = 22; v_on = 1'b1; v_T = 180; v_ah = 1'b1;
        settle_and_check("c8");
        clear_edge("c8");
        // c9: V slow (250 ticks) -> absent by threshold; H back to 12
        h_T = 12; v_T = 250;
        settle_and_check("c9");
        clear_edge("c9");
        // c10: level mode, ack ignored, swclr clears (R10)
        irq_edge_mode = 1'b0; v_T = 150;
        settle_and_check("c10");
        pulse_ack();
        chk("R10", "c10 irq kept after ack", int'(irq), 1);
        pulse_clr();
        chk("R10", "c10 irq after swclr", int'(irq), 0);
        // c11: disable, change inputs, outputs must hold (R1)
        irq_edge_mode = 1'b1;
        write_en(1'b0);
        chk("R1", "c11 en_o cleared", int'(en_o), 0);
        h_on = 1'b0; v_on = 1'b0;
        cycles(14 * 2 * TMO);
        chk("R1", "c11 h_present held", int'(h_present), 1);
        chk("R1", "c11 pwr held", int'(pwr_state), 0);
        chk("R1", "c11 irq not set", int'(irq), 0);
        write_en(1'b1);
        chk("R1", "c11 en_o set", int'(en_o), 1);
        settle_and_check("c11");
        clear_edge("c11");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule